// File: doc/BRIEF.md
# Serial Register Port

This block is a three-wire serial slave that gives a host access to a small register file. The host raises an enable line to open a transfer, then clocks in a 16-bit frame. The frame starts with a direction bit and a 7-bit address, followed by one data byte. Every field travels least significant bit first, and each bit is sampled on a rising edge of the serial clock. All three serial inputs are synchronised into the core clock domain, and every frame decision is made there.

On a write, the addressed control register is updated once the sixteenth rising edge has arrived. On a read, the block drives the data pin through a separate output and output-enable pair for the whole data byte. Only two registers can be read: a live status byte and a fixed identification byte. The 14-bit DAC word is split over two write-only registers. The high part is held in a shadow register, and the full word changes in a single step when the low part is written.

Top module: `ser_reg_port`

## Requirements
- R1: While rst_ni is low, and immediately after it rises, every control byte, the DAC word, the DAC flags and sdata_oe_o are zero.
- R2: A write frame consists of the following bits in order: bit 0 = 0 (write), bits 1..7 = address (LSB first), bits 8..15 = data (LSB first). The register at that address takes the data after the 16th rising serial clock edge. Control byte k sits at address CTRL_BASE+k (the default base is 02h) and is presented on ctrl_o[8k+7:8k].
- R3: Rising serial clock edges after the 16th within one enable window shift nothing and write nothing.
- R4: If the enable falls before the 16th rising edge, the frame is dropped and no register changes.
- R5: A write to address 00h loads only a shadow byte, and the DAC outputs stay unchanged. A write to address 01h with byte L sets dac_word_o to {shadow[5:0], L} and dac_flags_o to shadow[7:6], both in the same cycle.
- R6: A read frame has bit 0 = 1. The block drives data bit 0 after the 8th rising edge and each following data bit after the next rising edge. Address 70h returns status_i and address 7Fh returns CHIP_ID (default C6h).
- R7: A read of a write-only or unmapped address returns 00h.
- R8: Writes to 70h, 7Fh or unmapped addresses leave every control byte, the DAC word and the DAC flags unchanged.
- R9: sdata_oe_o is low while the enable is low and for the whole address byte. It is high only between the 8th and the 16th rising edges of a read frame.
- R10: Each rising edge of the enable restarts the bit count, so a complete frame that follows an aborted one is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| sen_i | input | 1 | Transfer enable, active high |
| sclk_i | input | 1 | Serial clock; data is sampled on its rising edge |
| sdata_i | input | 1 | Serial data from the host |
| sdata_o | output | 1 | Serial data to the host during a read data byte |
| sdata_oe_o | output | 1 | Output enable for the shared data pin |
| status_i | input | 8 | Live status byte returned at address 70h |
| ctrl_o | output | NUM_CTRL*8 | Write-only control bytes |
| dac_word_o | output | DAC_W | Committed DAC word |
| dac_flags_o | output | 16-DAC_W | Mode bits committed with the DAC word |

## Verification
The hardest conditions to reach from the ports are at the edges of the frame: clock pulses that arrive after the sixteenth edge, and an enable that drops one edge short of a complete frame. The stimulus reaches both with one frame-driving task that takes the number of clock pulses as an argument. It sends 20 pulses with the extra bits set to one, and it also sends 10-pulse and 15-pulse frames that are closed early. Each case is followed by a read-back of the affected control outputs. The DAC shadow is checked by writing the high byte, confirming that the outputs have not moved, and only then writing the low byte.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int HDR_BITS   = 1 + ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  localparam logic [ADDR_W-1:0] DAC_HI_ADDR = 7'h00;
  localparam logic [ADDR_W-1:0] DAC_LO_ADDR = 7'h01;
  localparam logic [ADDR_W-1:0] ID_ADDR     = 7'h7F;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/ser_reg_sync.sv
module ser_reg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe <= '0;
      else         pipe <= {pipe[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = pipe[STAGES-1];
  end
endmodule

// File: rtl/ser_reg_frame.sv
module ser_reg_frame
  import ser_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sen_i,
  input  logic              sclk_i,
  input  logic              sdat_i,
  output wr_req_t           wr_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sdata_o,
  output logic              sdata_oe_o
);
  logic                  sclk_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-2:0] frame_q;
  logic [FRAME_BITS-1:0] frame_nxt;
  logic [DATA_W-1:0]     out_q;
  logic                  oe_q;
  logic                  sclk_rise, shift_ev, hdr_done, frame_done;

  assign sclk_rise  = sclk_i & ~sclk_q;
  assign shift_ev   = sen_i & sclk_rise & (cnt_q < CNT_W'(FRAME_BITS));
  assign frame_nxt  = {sdat_i, frame_q};
  assign hdr_done   = shift_ev && (cnt_q == CNT_W'(HDR_BITS - 1));
  assign frame_done = shift_ev && (cnt_q == CNT_W'(FRAME_BITS - 1));

  // header sits in the top byte after 8 shifts
  assign rd_addr_o = frame_nxt[FRAME_BITS-1 -: ADDR_W];

  assign wr_o.en   = frame_done & ~frame_nxt[0];
  assign wr_o.addr = frame_nxt[ADDR_W:1];
  assign wr_o.data = frame_nxt[FRAME_BITS-1 -: DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      frame_q <= '0;
    end else if (!sen_i) begin
      cnt_q   <= '0;
      frame_q <= '0;
    end else if (shift_ev) begin
      cnt_q   <= cnt_q + 1'b1;
      frame_q <= frame_nxt[FRAME_BITS-1:1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q  <= 1'b0;
      out_q <= '0;
    end else if (!sen_i) begin
      oe_q  <= 1'b0;
      out_q <= '0;
    end else if (hdr_done) begin
      oe_q  <= frame_nxt[FRAME_BITS-HDR_BITS];
      out_q <= frame_nxt[FRAME_BITS-HDR_BITS] ? rd_data_i : '0;
    end else if (frame_done) begin
      oe_q  <= 1'b0;
    end else if (shift_ev) begin
      out_q <= out_q >> 1;
    end
  end

  assign sdata_o    = oe_q & out_q[0];
  assign sdata_oe_o = oe_q;

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_BITS));

  // R2
  wr_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o.en |=> cnt_q == CNT_W'(FRAME_BITS));

  // R9
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sen_i |=> !sdata_oe_o);

  // R9
  oe_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdata_oe_o) |-> cnt_q == CNT_W'(HDR_BITS));
endmodule

// File: rtl/ser_reg_file.sv
module ser_reg_file
  import ser_reg_pkg::*;
#(
  parameter int                NUM_CTRL    = 4,
  parameter logic [ADDR_W-1:0] CTRL_BASE   = 7'h02,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 7'h70,
  parameter logic [DATA_W-1:0] CHIP_ID     = 8'hC6,
  parameter int                DAC_W       = 14,
  localparam int               HI_BITS     = DAC_W - DATA_W,
  localparam int               FLAG_W      = DATA_W - HI_BITS
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  wr_req_t                    wr_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [DATA_W-1:0]          rd_data_o,
  input  logic [DATA_W-1:0]          status_i,
  output logic [NUM_CTRL*DATA_W-1:0] ctrl_o,
  output logic [DAC_W-1:0]           dac_word_o,
  output logic [FLAG_W-1:0]          dac_flags_o
);
  logic [DATA_W-1:0] dac_hi_q;
  logic [DAC_W-1:0]  dac_word_q;
  logic [FLAG_W-1:0] dac_flags_q;
  logic              hi_hit, lo_hit;

  assign hi_hit = wr_i.en && (wr_i.addr == DAC_HI_ADDR);
  assign lo_hit = wr_i.en && (wr_i.addr == DAC_LO_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_hi_q    <= '0;
      dac_word_q  <= '0;
      dac_flags_q <= '0;
    end else begin
      if (hi_hit) dac_hi_q <= wr_i.data;
      if (lo_hit) begin
        dac_word_q  <= {dac_hi_q[HI_BITS-1:0], wr_i.data};
        dac_flags_q <= dac_hi_q[DATA_W-1 -: FLAG_W];
      end
    end
  end

  assign dac_word_o  = dac_word_q;
  assign dac_flags_o = dac_flags_q;

  for (genvar k = 0; k < NUM_CTRL; k++) begin : g_ctrl
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CTRL_BASE + k);
    logic [DATA_W-1:0] q;
    logic              hit;
    assign hit = wr_i.en && (wr_i.addr == MY_ADDR);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (hit) q <= wr_i.data;
    end
    assign ctrl_o[k*DATA_W +: DATA_W] = q;

    // R8
    ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i.en && wr_i.addr == MY_ADDR) |=> $stable(ctrl_o[k*DATA_W +: DATA_W]));
  end

  // only status and ID are readable
  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == STATUS_ADDR) rd_data_o = status_i;
    if (rd_addr_i == ID_ADDR)     rd_data_o = CHIP_ID;
  end

  // R5
  dac_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i.en && wr_i.addr == DAC_LO_ADDR) |=> ($stable(dac_word_o) && $stable(dac_flags_o)));

  // R7
  rd_wo_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i != STATUS_ADDR && rd_addr_i != ID_ADDR) |-> rd_data_o == '0);
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
  import ser_reg_pkg::*;
#(
  parameter int         NUM_CTRL    = 4,
  parameter logic [6:0] CTRL_BASE   = 7'h02,
  parameter logic [6:0] STATUS_ADDR = 7'h70,
  parameter logic [7:0] CHIP_ID     = 8'hC6,
  parameter int         DAC_W       = 14,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sen_i,
  input  logic                  sclk_i,
  input  logic                  sdata_i,
  output logic                  sdata_o,
  output logic                  sdata_oe_o,
  input  logic [7:0]            status_i,
  output logic [NUM_CTRL*8-1:0] ctrl_o,
  output logic [DAC_W-1:0]      dac_word_o,
  output logic [15-DAC_W:0]     dac_flags_o
);
  logic [2:0]        sync_q;
  wr_req_t           wr;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  ser_reg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sen_i, sclk_i, sdata_i}),
    .q_o    (sync_q)
  );

  ser_reg_frame u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sen_i      (sync_q[2]),
    .sclk_i     (sync_q[1]),
    .sdat_i     (sync_q[0]),
    .wr_o       (wr),
    .rd_addr_o  (rd_addr),
    .rd_data_i  (rd_data),
    .sdata_o    (sdata_o),
    .sdata_oe_o (sdata_oe_o)
  );

  ser_reg_file #(
    .NUM_CTRL    (NUM_CTRL),
    .CTRL_BASE   (CTRL_BASE),
    .STATUS_ADDR (STATUS_ADDR),
    .CHIP_ID     (CHIP_ID),
    .DAC_W       (DAC_W)
  ) u_file (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .status_i    (status_i),
    .ctrl_o      (ctrl_o),
    .dac_word_o  (dac_word_o),
    .dac_flags_o (dac_flags_o)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (ctrl_o == '0 && dac_word_o == '0 && !sdata_oe_o));
endmodule

// File: tb/ser_reg_port_bench.sv
module ser_reg_port_bench;
  localparam int HALF = 8;
  localparam int NV   = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sen = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic        sdo, sdo_oe;
  logic [7:0]  status = 8'h5A;
  logic [31:0] ctrl;
  logic [13:0] dac;
  logic [1:0]  flags;

  int n_chk = 0, n_bad = 0, oe_bad = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ser_reg_port u_ser_reg_port (
    .clk_i (clk), .rst_ni (rst_ni), .sen_i (sen), .sclk_i (sclk),
    .sdata_i (sdi), .sdata_o (sdo), .sdata_oe_o (sdo_oe), .status_i (status),
    .ctrl_o (ctrl), .dac_word_o (dac), .dac_flags_o (flags)
  );

  // {kind, frame = {data, addr, rw}, expected}; kind 0 ctrl, 1 dac, 2 read
  localparam logic [35:0] VEC [NV] = '{
    {4'd0, 8'hA5, 7'h02, 1'b0, 16'h00A5},
    {4'd0, 8'h3C, 7'h05, 1'b0, 16'h003C},
    {4'd0, 8'h81, 7'h03, 1'b0, 16'h0081},
    {4'd2, 8'h00, 7'h7F, 1'b1, 16'h00C6},
    {4'd2, 8'h00, 7'h70, 1'b1, 16'h005A},
    {4'd2, 8'hFF, 7'h02, 1'b1, 16'h0000},
    {4'd2, 8'h00, 7'h40, 1'b1, 16'h0000},
    {4'd1, 8'hEB, 7'h00, 1'b0, 16'h0000},
    {4'd1, 8'h17, 7'h01, 1'b0, 16'h2B17},
    {4'd0, 8'h00, 7'h04, 1'b0, 16'h0000}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] f, input int nclk, output logic [7:0] rd);
    rd = '0;
    sen = 1'b1;
    tick(HALF);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 16) ? f[i] : 1'b1;
      tick(HALF);
      if (i < 8 && sdo_oe) oe_bad++;
      if (i >= 8 && i < 16) begin
        if (sdo_oe !== f[0]) oe_bad++;
        rd[i-8] = sdo;
      end
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
    tick(HALF);
    sen = 1'b0;
    tick(HALF);
    if (sdo_oe) oe_bad++;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0]  rd;
    logic [31:0] c_snap;
    logic [13:0] d_snap;
    tick(3);
    // R1
    chk("R1 ctrl", ctrl[15:0], 16'h0);
    chk("R1 dac", {flags, dac}, 16'h0);
    chk("R1 oe", {15'h0, sdo_oe}, 16'h0);
    rst_ni = 1'b1;
    tick(4);
    chk("R1 ctrl after", ctrl[31:16], 16'h0);

    for (int v = 0; v < NV; v++) begin
      logic [15:0] fr;
      logic [15:0] ex;
      int idx;
      fr = VEC[v][31:16];
      ex = VEC[v][15:0];
      send(fr, 16, rd);
      case (VEC[v][35:32])
        4'd0: begin
          idx = int'(fr[7:1]) - 2;
          chk("R2 write", {8'h0, ctrl[idx*8 +: 8]}, ex);
        end
        4'd1: chk("R5 dac", {2'b0, dac}, ex);
        default: chk(ex == 0 ? "R7 read" : "R6 read", {8'h0, rd}, ex);
      endcase
    end

    // R5 flags, shadow hold, second commit
    chk("R5 flags", {14'h0, flags}, 16'h3);
    send({8'h00, 7'h00, 1'b0}, 16, rd);
    chk("R5 shadow hold", {2'b0, dac}, 16'h2B17);
    send({8'h01, 7'h01, 1'b0}, 16, rd);
    chk("R5 commit", {flags, dac}, 16'h0001);

    // R3 overlong frame
    send({8'h96, 7'h04, 1'b0}, 20, rd);
    chk("R3 overlong", {8'h0, ctrl[23:16]}, 16'h0096);

    // R4 short frames
    send({8'h11, 7'h02, 1'b0}, 10, rd);
    chk("R4 abort 10", {8'h0, ctrl[7:0]}, 16'h00A5);
    send({8'h00, 7'h03, 1'b0}, 15, rd);
    chk("R4 abort 15", {8'h0, ctrl[15:8]}, 16'h0081);

    // R10 full frame after abort
    send({8'h42, 7'h02, 1'b0}, 16, rd);
    chk("R10 restart", {8'h0, ctrl[7:0]}, 16'h0042);

    // R8 writes to read-only and unmapped
    c_snap = ctrl;
    d_snap = dac;
    send({8'h00, 7'h7F, 1'b0}, 16, rd);
    send({8'hFF, 7'h70, 1'b0}, 16, rd);
    send({8'hFF, 7'h7A, 1'b0}, 16, rd);
    send({8'h77, 7'h06, 1'b0}, 16, rd);
    chk("R8 ctrl lo", ctrl[15:0], c_snap[15:0]);
    chk("R8 ctrl hi", ctrl[31:16], c_snap[31:16]);
    chk("R8 dac", {flags, dac}, {2'b00, d_snap});
    send({8'h00, 7'h7F, 1'b1}, 16, rd);
    chk("R6 id after write", {8'h0, rd}, 16'h00C6);

    // R9 pin release across all frames
    chk("R9 oe window", oe_bad[15:0], 16'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule